// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block buffers bulk-endpoint packets between the bus side and the local controller using two equal banks arranged as a ping-pong pair. One side fills a bank byte by byte, then marks the end of the packet. That hands the bank, together with its byte count, to the other side. The writer then moves on to the second bank. The reader drains the committed banks in the order they were handed over and releases each one after its last byte.

The same storage serves both directions of the endpoint. When the endpoint receives, the bus side is the writer and the controller is the reader. When it transmits, the roles swap. A direction input chooses between the two, and changing it empties the buffer. A bus-reset input empties it too.

Status is given by two flags. The full flag describes the bank currently being written, and it is raised only when that bank holds a complete maximum-size packet. The empty flag describes the bank currently being read. A registered overflow pulse marks a write that was discarded.

Top module: `pingpong_ep_buffer`

## Requirements
- R1: After reset, empty reads 1, full reads 0, overflow reads 0 and rdData reads 0x00.
- R2: Each bank holds BANK_BYTES bytes (64 by default). Both banks can hold a complete committed packet at the same time, which gives 128 bytes in total.
- R3: full is 1 exactly when the bank being written holds BANK_BYTES bytes. A packet shorter than that never sets full, whether the bank is still being filled or has been committed.
- R4: A wrEnd pulse commits the bank being written with its byte count, and a byte written by wrEn in the same cycle is included. The write side then moves to the other bank in the next cycle if that bank is free. Otherwise the write side stays on the committed bank until the other bank is released, and moves in the cycle after the release. A wrEnd on a bank holding no bytes is ignored.
- R5: rdData shows the next unread byte of the oldest committed bank (show-ahead), and rdEn consumes it. rdLast is 1 while the byte shown is the last one of its packet. Consuming that byte releases the bank, and the read side moves to the other bank.
- R6: empty is 1 whenever the bank being read holds no committed packet. Bytes that are written but not yet committed do not clear it.
- R7: A write is dropped when the target bank is already committed or already holds BANK_BYTES bytes. A dropped write raises overflow for exactly one cycle, in the cycle after it. The dropped byte never appears at rdData.
- R8: rdEn while empty returns rdData = 0x00 and does not move the read position. The first byte of a later packet is still read correctly.
- R9: A change of dirTx, or busReset held high at a clock edge, discards all data. After that edge empty reads 1, full reads 0 and overflow reads 0.
- R10: Full, empty, commit and read behaviour is the same with dirTx = 0 (receive) and dirTx = 1 (transmit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busReset | input | 1 | Flush request from a bus reset |
| dirTx | input | 1 | Endpoint direction: 1 = transmit, 0 = receive; any change flushes |
| wrEn | input | 1 | Write one byte into the bank being written |
| wrData | input | DATA_W | Byte to write |
| wrEnd | input | 1 | Writer end-of-packet: commit the current bank |
| rdEn | input | 1 | Consume the byte shown on rdData |
| rdData | output | DATA_W | Next unread byte, or 0 when empty |
| rdLast | output | 1 | The byte shown is the last one of its packet |
| full | output | 1 | The bank being written holds a maximum-size packet |
| empty | output | 1 | The bank being read holds no committed packet |
| overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
The bench targets the case where both banks hold 64-byte packets. A design that moved the write side onto the occupied bank would either overwrite the older packet or drop full too early. It checks that a short packet and an uncommitted partial fill never raise full or clear empty. It checks that a zero-length end marker is ignored; a design that committed it would lock the read side on a bank that can never be released. It also checks the following:
- a read from an empty buffer leaves the read position where it is, so a later packet starts at its first byte;
- a byte written past 64 is never read back;
- a direction change or a bus reset in the middle of a fill leaves nothing behind.

// File: rtl/pingpong_ep_pkg.sv
package pingpong_ep_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic wrStrobe;   // store wrData at the write position
    logic wrBankSel;  // bank receiving the byte
    logic rdValid;    // a committed byte is visible at the read position
    logic rdBankSel;  // bank being drained
  } ppStrobe_t;

endpackage

// File: rtl/pingpong_ep_ctrl.sv
module pingpong_ep_ctrl
  import pingpong_ep_pkg::*;
#(
  parameter int BANK_BYTES = 64,
  parameter int IDX_W      = $clog2(BANK_BYTES),
  parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             dirTx,
  input  logic             wrEn,
  input  logic             wrEnd,
  input  logic             rdEn,
  output ppStrobe_t        strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             full,
  output logic             empty,
  output logic             rdLast,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(BANK_BYTES);

  logic [CNT_W-1:0] bankCount [2];
  logic [1:0]       bankBusy;
  logic             wrBankQ;
  logic             rdBankQ;
  logic [IDX_W-1:0] rdIdxQ;
  logic             dirQ;
  logic             ovfQ;

  logic             flush;
  logic             wrOpen;
  logic             acceptWr;
  logic             dropWr;
  logic [CNT_W-1:0] fillNext;
  logic             doCommit;
  logic             popOk;
  logic             lastPop;
  logic             moveWr;

  assign flush    = busReset || (dirTx != dirQ);

  // Write side: a bank takes bytes only while uncommitted and not at capacity.
  assign wrOpen   = !bankBusy[wrBankQ] && (bankCount[wrBankQ] != CAP);
  assign acceptWr = wrEn && wrOpen;
  assign dropWr   = wrEn && !wrOpen;
  assign fillNext = bankCount[wrBankQ] + CNT_W'(acceptWr);
  assign doCommit = wrEnd && !bankBusy[wrBankQ] && (fillNext != '0);

  // Move the write side on commit if the other bank is free, or later once it frees.
  assign moveWr   = (doCommit && !bankBusy[!wrBankQ]) ||
                    (bankBusy[wrBankQ] && !bankBusy[!wrBankQ]);

  // Read side: only committed banks are visible.
  assign popOk    = rdEn && bankBusy[rdBankQ];
  assign rdLast   = bankBusy[rdBankQ] &&
                    ((CNT_W'(rdIdxQ) + CNT_W'(1)) == bankCount[rdBankQ]);
  assign lastPop  = popOk && rdLast;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN || flush) begin
        bankCount[b] <= '0;
        bankBusy[b]  <= 1'b0;
      end else begin
        if (acceptWr && (wrBankQ == 1'(b)))
          bankCount[b] <= bankCount[b] + CNT_W'(1);
        if (doCommit && (wrBankQ == 1'(b)))
          bankBusy[b] <= 1'b1;
        if (lastPop && (rdBankQ == 1'(b))) begin
          bankCount[b] <= '0;
          bankBusy[b]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrBankQ <= 1'b0;
      rdBankQ <= 1'b0;
      rdIdxQ  <= '0;
      ovfQ    <= 1'b0;
      dirQ    <= dirTx;
    end else begin
      ovfQ <= dropWr;
      if (moveWr)
        wrBankQ <= !wrBankQ;
      if (lastPop) begin
        rdIdxQ  <= '0;
        rdBankQ <= !rdBankQ;
      end else if (popOk) begin
        rdIdxQ <= rdIdxQ + IDX_W'(1);
      end
    end
  end

  assign strobes.wrStrobe  = acceptWr;
  assign strobes.wrBankSel = wrBankQ;
  assign strobes.rdValid   = bankBusy[rdBankQ];
  assign strobes.rdBankSel = rdBankQ;
  assign wrIdx    = bankCount[wrBankQ][IDX_W-1:0];
  assign rdIdx    = rdIdxQ;
  assign full     = (bankCount[wrBankQ] == CAP);
  assign empty    = !bankBusy[rdBankQ];
  assign overflow = ovfQ;

  // R7: writing while full is always reported one cycle later
  a_r7_full_write_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !flush) |=> overflow);

  // R8: a read on an empty buffer leaves the read position untouched
  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty && !flush) |=> ($stable(rdIdxQ) && $stable(rdBankQ)));

  // R9: flush leaves the buffer empty with no pending flags
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (empty && !full && !overflow));

  // R5: consuming the last byte moves the read side to the other bank
  a_r5_last_moves_bank: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdLast && !flush) |=> (rdBankQ != $past(rdBankQ)));

  // R3: an end marker with no byte added cannot raise full
  a_r3_short_commit_not_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnd && !wrEn && !full && !flush) |=> !full);

endmodule

// File: rtl/pingpong_ep_datapath.sv
module pingpong_ep_datapath
  import pingpong_ep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  parameter int IDX_W      = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  ppStrobe_t         strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int ENTRIES = 2 * BANK_BYTES;

  logic [DATA_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (strobes.wrStrobe)
      store[{strobes.wrBankSel, wrIdx}] <= wrData;
  end

  // Show-ahead read; zero when nothing committed is visible.
  assign rdData = strobes.rdValid ? store[{strobes.rdBankSel, rdIdx}] : '0;

endmodule

// File: rtl/pingpong_ep_buffer.sv
module pingpong_ep_buffer
  import pingpong_ep_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              dirTx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnd,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdLast,
  output logic              full,
  output logic              empty,
  output logic              overflow
);

  localparam int IDX_W = $clog2(BANK_BYTES);
  localparam int CNT_W = $clog2(BANK_BYTES + 1);

  ppStrobe_t        strobes;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  pingpong_ep_ctrl #(
    .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .dirTx(dirTx),
    .wrEn(wrEn), .wrEnd(wrEnd), .rdEn(rdEn),
    .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .full(full), .empty(empty), .rdLast(rdLast), .overflow(overflow)
  );

  pingpong_ep_datapath #(
    .DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .rdData(rdData)
  );

  // R8: nothing but zero leaves the read port while empty
  a_r8_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (rdData == '0));

endmodule

// File: tb/test_pingpong_ep_buffer.sv
module test_pingpong_ep_buffer;

  localparam int DW  = 8;
  localparam int CAP = 64;

  logic          clk = 1'b0;
  logic          rstN, busReset, dirTx, wrEn, wrEnd, rdEn;
  logic [DW-1:0] wrData, rdData;
  logic          rdLast, full, empty, overflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  pingpong_ep_buffer #(.DATA_W(DW), .BANK_BYTES(CAP)) i_pingpong_ep_buffer (
    .clk(clk), .rstN(rstN), .busReset(busReset), .dirTx(dirTx),
    .wrEn(wrEn), .wrData(wrData), .wrEnd(wrEnd), .rdEn(rdEn),
    .rdData(rdData), .rdLast(rdLast), .full(full), .empty(empty),
    .overflow(overflow)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushByte(input int val);
    wrEn = 1'b1; wrData = DW'(val);
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic commit();
    wrEnd = 1'b1;
    cyc();
    wrEnd = 1'b0;
  endtask

  // Write n bytes (seed, seed+1, ...); check that full only appears at capacity (R3).
  task automatic pushBytes(input int seed, input int n);
    for (int i = 0; i < n; i++) begin
      pushByte(seed + i);
      chk("R3 full tracks bank fill", int'(full), (i + 1 == CAP) ? 1 : 0);
    end
  endtask

  // Read n bytes, checking data and last marker, then that empty shows the result (R5).
  task automatic popBytes(input int seed, input int n, input int emptyAfter);
    for (int i = 0; i < n; i++) begin
      chk("R5 read data in order", int'(rdData), (seed + i) & 8'hFF);
      chk("R5 last marker", int'(rdLast), (i == n - 1) ? 1 : 0);
      rdEn = 1'b1;
      cyc();
      rdEn = 1'b0;
    end
    chk("R6 empty after drain", int'(empty), emptyAfter);
  endtask

  task automatic t_reset();
    rstN = 1'b0; busReset = 1'b0; dirTx = 1'b0;
    wrEn = 1'b0; wrEnd = 1'b0; rdEn = 1'b0; wrData = '0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    chk("R1 empty at reset", int'(empty), 1);
    chk("R1 full at reset", int'(full), 0);
    chk("R1 overflow at reset", int'(overflow), 0);
    chk("R1 rdData at reset", int'(rdData), 0);
  endtask

  task automatic t_shortPacket();
    pushBytes(8'h10, 5);
    chk("R6 uncommitted data stays invisible", int'(empty), 1);
    commit();
    chk("R3 short packet not full", int'(full), 0);
    chk("R6 committed packet visible", int'(empty), 0);
    popBytes(8'h10, 5, 1);
  endtask

  task automatic t_fullPacket();
    pushBytes(8'h40, CAP);
    chk("R6 full but uncommitted", int'(empty), 1);
    commit();
    chk("R4 writer moved to free bank", int'(full), 0);
    chk("R4 commit makes data visible", int'(empty), 0);
    popBytes(8'h40, CAP, 1);
  endtask

  task automatic t_bothBanks();
    pushBytes(8'h80, CAP);
    commit();
    chk("R4 first commit moves writer", int'(full), 0);
    pushBytes(8'hC0, CAP);
    commit();
    chk("R2 both banks held, writer stays", int'(full), 1);
    pushByte(8'hEE);
    chk("R7 overflow on write into held bank", int'(overflow), 1);
    cyc();
    chk("R7 overflow lasts one cycle", int'(overflow), 0);
    popBytes(8'h80, CAP, 0);
    cyc();
    chk("R4 writer moves after release", int'(full), 0);
    popBytes(8'hC0, CAP, 1);
  endtask

  task automatic t_overfill();
    pushBytes(8'h05, CAP);
    pushByte(8'hEE);
    chk("R7 overflow past capacity", int'(overflow), 1);
    chk("R7 full stays after drop", int'(full), 1);
    commit();
    chk("R7 overflow pulse ends", int'(overflow), 0);
    popBytes(8'h05, CAP, 1);
    chk("R7 dropped byte absent", int'(rdData), 0);
  endtask

  task automatic t_emptyRead();
    chk("R8 empty read data", int'(rdData), 0);
    rdEn = 1'b1;
    cyc(); cyc();
    rdEn = 1'b0;
    chk("R8 still empty", int'(empty), 1);
    chk("R8 still zero", int'(rdData), 0);
    pushBytes(8'h30, 3);
    commit();
    popBytes(8'h30, 3, 1);
  endtask

  task automatic t_zeroLength();
    commit();
    chk("R4 zero-length end ignored", int'(empty), 1);
    wrEn = 1'b1; wrEnd = 1'b1; wrData = 8'h77;
    cyc();
    wrEn = 1'b0; wrEnd = 1'b0;
    chk("R4 same-cycle byte committed", int'(empty), 0);
    popBytes(8'h77, 1, 1);
  endtask

  task automatic t_flush();
    pushBytes(8'h20, 10);
    commit();
    pushBytes(8'h50, CAP);
    dirTx = 1'b1;
    cyc();
    chk("R9 direction change empties", int'(empty), 1);
    chk("R9 direction change clears full", int'(full), 0);
    chk("R9 flushed data gone", int'(rdData), 0);
    // R10: same behaviour while transmitting
    pushBytes(8'h11, CAP);
    commit();
    chk("R10 transmit commit moves writer", int'(full), 0);
    pushBytes(8'h61, 6);
    commit();
    popBytes(8'h11, CAP, 0);
    popBytes(8'h61, 6, 1);
    pushBytes(8'h90, 7);
    commit();
    busReset = 1'b1;
    cyc();
    busReset = 1'b0;
    chk("R9 bus reset empties", int'(empty), 1);
    chk("R9 bus reset data gone", int'(rdData), 0);
    pushBytes(8'hA0, 2);
    commit();
    popBytes(8'hA0, 2, 1);
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    t_reset();
    t_shortPacket();
    t_fullPacket();
    t_bothBanks();
    t_overfill();
    t_emptyRead();
    t_zeroLength();
    t_flush();
    finish();
  end

endmodule